// File: doc/BRIEF.md
# Transistor Thermal Overload Monitor

This block estimates whether any of three external driver transistor pairs is running too hot. Each pair delivers a stream of power samples on its own input. The block smooths every stream with a first-order low-pass filter whose pole is set per channel. It compares the smoothed value with a per-channel 8-bit limit. When any channel goes over its limit, the block records a power-alarm event. That event can raise an interrupt, and it can also ask the line-state controller to drop the line to its Open state.

A second, independent function counts supply trouble. Each rising edge of either a supply-voltage-low flag or a current-high flag adds one to an 8-bit count, which stops at 255. All settings, the status and the count are reached through a small byte-wide register bus with combinational read data.

Top module: `thermal_guard`

## Requirements
- R1: After a synchronous active-high reset, all filter state, the sticky alarm bit, both enables and the supply-event count are zero, and irq and open_req are low.
- R2: On each cycle where a channel's valid bit is high, its filter state y (16 integer and 8 fraction bits) becomes y + (x - y)·C/8192, with x the 16-bit sample and C the channel's 13-bit coefficient. Without valid, or with C = 0, y does not change.
- R3: C[7:0] of channels 0, 1 and 2 is written at addresses 0x0, 0x1 and 0x2. C[11:8] of channel 0 sits in bits [3:0] of 0x3, of channel 1 in bits [7:4] of 0x3, and of channel 2 in bits [3:0] of 0x4. C[12] of channels 0, 1 and 2 sits in bits 4, 5 and 6 of 0x4.
- R4: Thresholds for channels 0, 1 and 2 are at 0x5, 0x6 and 0x7. Channels 0 and 2 are over when floor(y)>>8 is greater than the threshold. Channel 1 uses a scale eight times finer and is over when floor(y)>>5 is greater than the threshold.
- R5: Bit 0 of the status register at 0x9 is a sticky alarm bit. It is set one cycle after the OR of the channel over-flags rises and is cleared by writing 1 to it. A combined alarm that merely stays high does not set it again.
- R6: irq equals the sticky alarm bit gated by the interrupt enable, bit 0 of the control register at 0x8.
- R7: When the auto-open enable (bit 1 of 0x8) is set, open_req pulses high for exactly one cycle, one cycle after the combined alarm rises. No pulse is issued when the enable is clear.
- R8: The count at 0xA increments once on a cycle where vdd_low or idd_high (or both) rises, does not count steady levels, and holds at 255.
- R9: Status bits [3:1] read the live over-flags of channels 0, 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_valid | input | 3 | Per-channel sample strobe |
| smp_power | input | 48 | Three 16-bit power samples, channel 0 in the low bits |
| vdd_low | input | 1 | Supply-voltage-low flag |
| idd_high | input | 1 | Current-high flag |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr |
| irq | output | 1 | Power-alarm interrupt |
| open_req | output | 1 | One-cycle request to force the line Open |

## Verification
The assertions assume that the bus writes only the status register to clear the sticky bit and that the two supply flags are plain synchronous levels. They also assume that the coefficient is below 8192, so one filter step never overshoots the sample. The stimulus drives all inputs on the falling edge, keeps coefficients in the 13-bit range by construction of the register layout, and picks samples and coefficients that halve or quarter the error each step. This makes every expected filter value exact. Thresholds are placed one code on either side of the resulting value to exercise both sides of each comparison.

// File: rtl/thermal_guard_pkg.sv
package thermal_guard_pkg;

    localparam int NCH          = 3;
    localparam int COEF_W       = 13;
    localparam int THR_W        = 8;
    localparam int FRAC_W       = 8;
    localparam int COARSE_SHIFT = 8;
    localparam int FINE_SHIFT   = 5;
    localparam int CNT_W        = 8;
    localparam int ADDR_W       = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_COEF_LO0 = 4'h0,
        RA_COEF_LO1 = 4'h1,
        RA_COEF_LO2 = 4'h2,
        RA_COEF_HIA = 4'h3,
        RA_COEF_HIB = 4'h4,
        RA_THR0     = 4'h5,
        RA_THR1     = 4'h6,
        RA_THR2     = 4'h7,
        RA_CTRL     = 4'h8,
        RA_STAT     = 4'h9,
        RA_EVCNT    = 4'hA
    } reg_addr_e;

    typedef struct packed {
        logic auto_open;
        logic irq_en;
    } ctrl_t;

    function automatic int cmp_shift(input int ch, input int fine_ch);
        return (ch == fine_ch) ? FINE_SHIFT : COARSE_SHIFT;
    endfunction

endpackage

// File: rtl/tg_lpf_chan.sv
module tg_lpf_chan #(
    parameter int PW     = 16,
    parameter int CW     = 13,
    parameter int FW     = 8,
    parameter int TW     = 8,
    parameter int SHIFT  = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          s_valid,
    input  logic [PW-1:0] s_power,
    input  logic [CW-1:0] coef,
    input  logic [TW-1:0] thr,
    output logic          over
);
    localparam int ACCW = PW + FW;
    localparam int DW   = ACCW + 1;
    localparam int PRW  = DW + CW + 1;

    logic [ACCW-1:0]       acc_q;
    logic [ACCW-1:0]       acc_n;
    logic signed [DW-1:0]  diff;
    logic signed [PRW-1:0] prod;
    logic signed [PRW-1:0] step;
    logic [PW-1:0]         y_int;

    always_comb begin
        diff  = $signed({1'b0, s_power, {FW{1'b0}}}) - $signed({1'b0, acc_q});
        prod  = PRW'(diff) * PRW'($signed({1'b0, coef}));
        step  = prod >>> CW;
        acc_n = acc_q + step[ACCW-1:0];
        y_int = acc_q[ACCW-1:FW];
        over  = (y_int >> SHIFT) > {{(PW-TW){1'b0}}, thr};
    end

    always_ff @(posedge clk) begin
        if (rst)          acc_q <= '0;
        else if (s_valid) acc_q <= acc_n;
    end

    // R2
    zero_coef_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (s_valid && coef == '0) |=> $stable(acc_q));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !s_valid |=> $stable(acc_q));

endmodule

// File: rtl/tg_evcnt.sv
module tg_evcnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flag_a,
    input  logic             flag_b,
    output logic [CNT_W-1:0] count
);
    localparam logic [CNT_W-1:0] CMAX = '1;

    logic fa_q, fb_q, bump;

    assign bump = (flag_a & ~fa_q) | (flag_b & ~fb_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            fa_q  <= 1'b0;
            fb_q  <= 1'b0;
            count <= '0;
        end else begin
            fa_q <= flag_a;
            fb_q <= flag_b;
            if (bump && count != CMAX) count <= count + 1'b1;
        end
    end

    // R8
    cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
        count == CMAX |=> count == CMAX);

    // R8
    cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
        count != CMAX |=> (count == $past(count) || count == $past(count) + 1'b1));

endmodule

// File: rtl/tg_regs.sv
module tg_regs
    import thermal_guard_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [7:0]            wdata,
    input  logic                  alarm_rise,
    input  logic [NCH-1:0]        live,
    input  logic [CNT_W-1:0]      evcnt,
    output logic [7:0]            rdata,
    output logic [NCH*COEF_W-1:0] coefs,
    output logic [NCH*THR_W-1:0]  thrs,
    output ctrl_t                 ctrl,
    output logic                  sticky
);
    logic [7:0]       coef_lo [NCH];
    logic [THR_W-1:0] thr_q   [NCH];
    logic [7:0]       hi_a;
    logic [6:0]       hi_b;
    logic             clr;

    assign clr = we && reg_addr_e'(addr) == RA_STAT && wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NCH; i++) begin
                coef_lo[i] <= '0;
                thr_q[i]   <= '0;
            end
            hi_a   <= '0;
            hi_b   <= '0;
            ctrl   <= '0;
            sticky <= 1'b0;
        end else begin
            if (we) begin
                case (reg_addr_e'(addr))
                    RA_COEF_LO0: coef_lo[0] <= wdata;
                    RA_COEF_LO1: coef_lo[1] <= wdata;
                    RA_COEF_LO2: coef_lo[2] <= wdata;
                    RA_COEF_HIA: hi_a       <= wdata;
                    RA_COEF_HIB: hi_b       <= wdata[6:0];
                    RA_THR0:     thr_q[0]   <= wdata;
                    RA_THR1:     thr_q[1]   <= wdata;
                    RA_THR2:     thr_q[2]   <= wdata;
                    RA_CTRL:     ctrl       <= ctrl_t'(wdata[1:0]);
                    default: ;
                endcase
            end
            if (alarm_rise)  sticky <= 1'b1;
            else if (clr)    sticky <= 1'b0;
        end
    end

    assign coefs[0*COEF_W +: COEF_W] = {hi_b[4], hi_a[3:0], coef_lo[0]};
    assign coefs[1*COEF_W +: COEF_W] = {hi_b[5], hi_a[7:4], coef_lo[1]};
    assign coefs[2*COEF_W +: COEF_W] = {hi_b[6], hi_b[3:0], coef_lo[2]};

    for (genvar g = 0; g < NCH; g++) begin : g_thr
        assign thrs[g*THR_W +: THR_W] = thr_q[g];
    end

    always_comb begin
        case (reg_addr_e'(addr))
            RA_COEF_LO0: rdata = coef_lo[0];
            RA_COEF_LO1: rdata = coef_lo[1];
            RA_COEF_LO2: rdata = coef_lo[2];
            RA_COEF_HIA: rdata = hi_a;
            RA_COEF_HIB: rdata = {1'b0, hi_b};
            RA_THR0:     rdata = thr_q[0];
            RA_THR1:     rdata = thr_q[1];
            RA_THR2:     rdata = thr_q[2];
            RA_CTRL:     rdata = {6'b0, ctrl};
            RA_STAT:     rdata = {4'b0, live, sticky};
            RA_EVCNT:    rdata = evcnt;
            default:     rdata = 8'h00;
        endcase
    end

    // R5
    sticky_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(sticky) |-> $past(alarm_rise));

    // R5
    sticky_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (sticky && !clr) |=> sticky);

endmodule

// File: rtl/thermal_guard.sv
module thermal_guard
    import thermal_guard_pkg::*;
#(
    parameter int PW      = 16,
    parameter int FINE_CH = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    smp_valid,
    input  logic [NCH*PW-1:0] smp_power,
    input  logic              vdd_low,
    input  logic              idd_high,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              irq,
    output logic              open_req
);
    logic [NCH*COEF_W-1:0] coefs;
    logic [NCH*THR_W-1:0]  thrs;
    logic [NCH-1:0]        over;
    logic [CNT_W-1:0]      evcnt;
    ctrl_t                 ctrl;
    logic                  sticky;
    logic                  alarm_any, alarm_q, alarm_rise;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        tg_lpf_chan #(
            .PW    (PW),
            .CW    (COEF_W),
            .FW    (FRAC_W),
            .TW    (THR_W),
            .SHIFT (cmp_shift(g, FINE_CH))
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .s_valid (smp_valid[g]),
            .s_power (smp_power[g*PW +: PW]),
            .coef    (coefs[g*COEF_W +: COEF_W]),
            .thr     (thrs[g*THR_W +: THR_W]),
            .over    (over[g])
        );
    end

    assign alarm_any  = |over;
    assign alarm_rise = alarm_any & ~alarm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            alarm_q  <= 1'b0;
            open_req <= 1'b0;
        end else begin
            alarm_q  <= alarm_any;
            open_req <= alarm_rise & ctrl.auto_open;
        end
    end

    assign irq = sticky & ctrl.irq_en;

    tg_regs u_regs (
        .clk        (clk),
        .rst        (rst),
        .we         (reg_we),
        .addr       (reg_addr),
        .wdata      (reg_wdata),
        .alarm_rise (alarm_rise),
        .live       (over),
        .evcnt      (evcnt),
        .rdata      (reg_rdata),
        .coefs      (coefs),
        .thrs       (thrs),
        .ctrl       (ctrl),
        .sticky     (sticky)
    );

    tg_evcnt #(.CNT_W(CNT_W)) u_evcnt (
        .clk    (clk),
        .rst    (rst),
        .flag_a (vdd_low),
        .flag_b (idd_high),
        .count  (evcnt)
    );

    // R7
    open_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        open_req |=> !open_req);

    // R7
    open_cause_chk: assert property (@(posedge clk) disable iff (rst)
        open_req |-> ($past(alarm_rise) && $past(ctrl.auto_open)));

    // R6
    irq_source_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> sticky);

endmodule

// File: tb/thermal_guard_bench.sv
module thermal_guard_bench;
    localparam int CLK_PERIOD = 10;
    localparam int PW  = 16;
    localparam int NCH = 3;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    smp_valid = '0;
    logic [NCH*PW-1:0] smp_power = '0;
    logic              vdd_low = 1'b0;
    logic              idd_high = 1'b0;
    logic              reg_we = 1'b0;
    logic [3:0]        reg_addr = '0;
    logic [7:0]        reg_wdata = '0;
    logic [7:0]        reg_rdata;
    logic              irq;
    logic              open_req;

    int checks = 0;
    int errors = 0;
    int open_cnt = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermal_guard u_thermal_guard (
        .clk(clk), .rst(rst), .smp_valid(smp_valid), .smp_power(smp_power),
        .vdd_low(vdd_low), .idd_high(idd_high), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .open_req(open_req)
    );

    always @(negedge clk) if (open_req) open_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; smp_valid = '0; vdd_low = 0; idd_high = 0; reg_we = 0;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
        open_cnt = 0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic push(input int ch, input logic [PW-1:0] x);
        smp_valid[ch] = 1'b1;
        smp_power[ch*PW +: PW] = x;
        @(negedge clk);
        smp_valid = '0;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        rd(4'h9, d); check(d == 8'h00, "R1 status", d, 0);
        rd(4'h8, d); check(d == 8'h00, "R1 ctrl", d, 0);
        rd(4'hA, d); check(d == 8'h00, "R1 count", d, 0);
        check(irq == 1'b0 && open_req == 1'b0, "R1 outputs", {irq, open_req}, 0);
    endtask

    // y: 0 -> 2048 -> 3072 with C=4096 and x=4096
    task automatic t_filter();
        logic [7:0] d;
        do_reset();
        wr(4'h4, 8'h10);            // ch0 C[12]=1 -> C=4096
        wr(4'h5, 8'd10);            // ch0 threshold 10 (coarse)
        wr(4'h7, 8'd0);             // ch2 threshold 0, C stays 0
        push(0, 16'd4096);
        rd(4'h9, d); check(d[1] == 1'b0, "R2 first step below", d[1], 0);
        repeat (5) @(negedge clk);
        rd(4'h9, d); check(d[1] == 1'b0, "R2 no update without valid", d[1], 0);
        push(0, 16'd4096);
        rd(4'h9, d); check(d[1] == 1'b1, "R9 second step over", d[1], 1);
        push(2, 16'hFFFF); push(2, 16'hFFFF);
        rd(4'h9, d); check(d[3] == 1'b0, "R2 zero coefficient holds", d[3], 0);
    endtask

    // one sample x=4096, C=4096 -> y=2048: coarse 8, fine 64
    task automatic t_scale();
        logic [7:0] d;
        do_reset();
        wr(4'h4, 8'h30);            // ch0 and ch1 C[12]=1
        wr(4'h5, 8'd8);
        wr(4'h6, 8'd64);
        push(0, 16'd4096); push(1, 16'd4096);
        rd(4'h9, d); check(d[2:1] == 2'b00, "R4 equal not over", d[2:1], 0);
        wr(4'h5, 8'd7);
        wr(4'h6, 8'd63);
        rd(4'h9, d); check(d[2:1] == 2'b11, "R4 one below over", d[2:1], 3);
    endtask

    // C=2048 in bits [11:8] of each channel, x=4096 -> y=1024
    task automatic t_hibits();
        logic [7:0] d;
        do_reset();
        wr(4'h3, 8'h88);            // ch0 and ch1 C[11:8]=8
        wr(4'h4, 8'h08);            // ch2 C[11:8]=8
        wr(4'h5, 8'd4); wr(4'h6, 8'd32); wr(4'h7, 8'd4);
        push(0, 16'd4096); push(1, 16'd4096); push(2, 16'd4096);
        rd(4'h9, d); check(d[3:1] == 3'b000, "R3 high bits below", d[3:1], 0);
        wr(4'h5, 8'd3); wr(4'h6, 8'd31); wr(4'h7, 8'd3);
        rd(4'h9, d); check(d[3:1] == 3'b111, "R3 high bits over", d[3:1], 7);
    endtask

    task automatic t_alarm();
        logic [7:0] d;
        do_reset();
        wr(4'h8, 8'h02);            // auto-open only
        wr(4'h4, 8'h10); wr(4'h5, 8'd7);
        push(0, 16'd4096);
        repeat (3) @(negedge clk);
        check(open_cnt == 1, "R7 single open pulse", open_cnt, 1);
        rd(4'h9, d); check(d[0] == 1'b1, "R5 sticky set", d[0], 1);
        check(irq == 1'b0, "R6 irq masked", irq, 0);
        wr(4'h8, 8'h03);
        #1; check(irq == 1'b1, "R6 irq enabled", irq, 1);
        wr(4'h9, 8'h01);
        repeat (3) @(negedge clk);
        rd(4'h9, d); check(d[0] == 1'b0, "R5 cleared and not re-set by level", d[0], 0);
        check(irq == 1'b0, "R6 irq follows clear", irq, 0);
        check(open_cnt == 1, "R7 no pulse on held alarm", open_cnt, 1);
        do_reset();
        wr(4'h4, 8'h10); wr(4'h5, 8'd7);
        push(0, 16'd4096);
        repeat (3) @(negedge clk);
        check(open_cnt == 0, "R7 disabled no pulse", open_cnt, 0);
        rd(4'h9, d); check(d[0] == 1'b1, "R5 sticky without enables", d[0], 1);
    endtask

    task automatic t_counter();
        logic [7:0] d;
        do_reset();
        vdd_low = 1'b1; @(negedge clk);
        rd(4'hA, d); check(d == 8'd1, "R8 voltage rise", d, 1);
        repeat (3) @(negedge clk);
        rd(4'hA, d); check(d == 8'd1, "R8 level ignored", d, 1);
        vdd_low = 1'b0; @(negedge clk);
        vdd_low = 1'b1; idd_high = 1'b1; @(negedge clk);
        rd(4'hA, d); check(d == 8'd2, "R8 joint rise once", d, 2);
        vdd_low = 1'b0; idd_high = 1'b0; @(negedge clk);
        idd_high = 1'b1; @(negedge clk);
        rd(4'hA, d); check(d == 8'd3, "R8 current rise", d, 3);
        for (int i = 0; i < 300; i++) begin
            idd_high = 1'b0; @(negedge clk);
            idd_high = 1'b1; @(negedge clk);
        end
        rd(4'hA, d); check(d == 8'd255, "R8 saturates", d, 255);
    endtask

    initial begin
        t_reset();
        t_filter();
        t_scale();
        t_hibits();
        t_alarm();
        t_counter();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule